// File: doc/BRIEF.md
# USB Full/Low-Speed NRZI Packet Receiver

This block sits behind a line sampler that already delivers one J, K, SE0 or SE1 code per bit period, qualified by a bit strobe. It waits for the bus to leave idle with a K, checks the rest of the eight-bit SYNC pattern, and then decodes the line as NRZI. Stuffed zeros are removed. Payload bits are packed into bytes least significant bit first, and each byte is handed out with a one-cycle valid pulse.

A properly framed end of packet gives a one-cycle EOP pulse. A stuffing violation gives a one-cycle error pulse, and so does a single-ended zero that arrives part way through a byte, an SE1, or a broken end-of-packet sequence. After an error the rest of the packet is ignored and the receiver hunts for the next SYNC. CRC and PID handling are left to the logic downstream.

Top module: `usb_nrzi_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released until a packet arrives, `rx_valid`, `rx_eop`, `rx_err` and `rx_active` are 0 and `rx_data` is 0.
- R2: `line_st` is read only on cycles where `bit_en` is 1, with 2'b01 = J, 2'b10 = K, 2'b00 = SE0 and 2'b11 = SE1. A packet starts when a sampled J is followed by a sampled K. The next seven samples must be J K J K J K K. On the first sample that differs, the receiver goes back to hunting and produces no output.
- R3: After SYNC the NRZI reference is the closing K. A sample equal to the reference decodes as 1, and a different sample decodes as 0. Bits fill a byte from bit 0 upward. Each completed byte gives exactly one `rx_valid` pulse, with the byte on `rx_data`, on the clock after the strobe of its eighth bit.
- R4: The closing K of SYNC counts as the first 1 of a run. After six decoded 1s in a row, the next decoded 0 is dropped and the run count restarts.
- R5: If a 1 arrives where a stuffed 0 is due, `rx_err` pulses once. The partial byte is dropped, and no further output comes from that packet.
- R6: An SE0 at a byte boundary, then a second SE0, then a J gives one `rx_eop` pulse on the clock after the J strobe.
- R7: `rx_err` pulses once in each of these cases: an SE0 with a partial byte pending, an SE1 anywhere inside a packet, or an end sequence that is not SE0, SE0, J.
- R8: After an EOP or an error, the receiver hunts again. It needs a fresh J-then-K before it will recognise a new packet.
- R9: `rx_active` is 1 from the clock after the SYNC's last K until the packet ends, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-period strobe qualifying `line_st` |
| line_st | input | 2 | Sampled line state: 01 J, 10 K, 00 SE0, 11 SE1 |
| rx_data | output | BYTE_W | Last completed byte |
| rx_valid | output | 1 | One-cycle pulse per completed byte |
| rx_eop | output | 1 | One-cycle pulse on a good end of packet |
| rx_err | output | 1 | One-cycle pulse on a stuffing or framing error |
| rx_active | output | 1 | High while inside a packet after SYNC |

## Verification
The assertions assume that `line_st` is only meaningful on strobe cycles and that strobes never come on consecutive clocks, so every output pulse follows one strobed sample. The stimulus keeps to this rule. It raises `bit_en` for one clock in every two, and it drives the complement of the current symbol on the gap cycles, so any sampling outside a strobe would show up.

The packets come from an independent NRZI encoder with stuffing. The error cases turn stuffing off, or inject SE0 and SE1 symbols directly.

// File: rtl/usb_nrzi_rx.sv
module usb_nrzi_rx #(
  parameter int STUFF_RUN = 6,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [1:0]        line_st,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_eop,
  output logic              rx_err,
  output logic              rx_active
);
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 2);
  localparam logic [1:0] LS_SE0 = 2'b00, LS_J = 2'b01, LS_K = 2'b10, LS_SE1 = 2'b11;

  typedef enum logic [2:0] {S_HUNT, S_SYNC, S_DATA, S_EOP1, S_EOP2} st_t;

  st_t               st;
  logic [1:0]        prev_ls, ref_ls;
  logic [2:0]        sync_idx;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ONES_W-1:0] ones_cnt;
  logic [BYTE_W-1:0] shreg;

  wire             dec_bit   = (line_st == ref_ls);
  wire [1:0]       sync_exp  = (sync_idx == 3'd7 || !sync_idx[0]) ? LS_K : LS_J;
  wire             byte_done = (bit_cnt == CNT_W'(BYTE_W - 1));
  wire             stuff_due = (ones_cnt == ONES_W'(STUFF_RUN));
  wire [BYTE_W-1:0] nxt_sh   = {dec_bit, shreg[BYTE_W-1:1]};

  assign rx_active = (st == S_DATA) || (st == S_EOP1) || (st == S_EOP2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      prev_ls  <= LS_SE0;
      ref_ls   <= LS_J;
      sync_idx <= '0;
      bit_cnt  <= '0;
      ones_cnt <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_eop   <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_eop   <= 1'b0;
      rx_err   <= 1'b0;
      if (bit_en) begin
        prev_ls <= line_st;
        case (st)
          S_HUNT: begin
            ref_ls <= LS_J;
            if (prev_ls == LS_J && line_st == LS_K) begin
              st       <= S_SYNC;
              sync_idx <= 3'd1;
            end
          end
          S_SYNC: begin
            if (line_st != sync_exp) st <= S_HUNT;
            else if (sync_idx == 3'd7) begin
              st       <= S_DATA;
              ref_ls   <= LS_K;
              ones_cnt <= ONES_W'(1);
              bit_cnt  <= '0;
            end else sync_idx <= sync_idx + 3'd1;
          end
          S_DATA: begin
            if (line_st == LS_SE0) begin
              if (bit_cnt == '0) st <= S_EOP1;
              else begin
                rx_err <= 1'b1;
                st     <= S_HUNT;
              end
            end else if (line_st == LS_SE1) begin
              rx_err <= 1'b1;
              st     <= S_HUNT;
            end else begin
              ref_ls <= line_st;
              if (stuff_due) begin
                if (dec_bit) begin
                  rx_err <= 1'b1;
                  st     <= S_HUNT;
                end else ones_cnt <= '0;
              end else begin
                shreg    <= nxt_sh;
                ones_cnt <= dec_bit ? ones_cnt + ONES_W'(1) : '0;
                bit_cnt  <= byte_done ? '0 : bit_cnt + CNT_W'(1);
                if (byte_done) begin
                  rx_data  <= nxt_sh;
                  rx_valid <= 1'b1;
                end
              end
            end
          end
          S_EOP1: begin
            if (line_st == LS_SE0) st <= S_EOP2;
            else begin
              rx_err <= 1'b1;
              st     <= S_HUNT;
            end
          end
          S_EOP2: begin
            if (line_st == LS_J) rx_eop <= 1'b1;
            else rx_err <= 1'b1;
            st <= S_HUNT;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  // R6 R7
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_eop, rx_err}));

  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_eop || rx_err) |-> $past(bit_en));

  // R2
  hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(bit_cnt) && $stable(st));

  // R4
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_cnt <= ONES_W'(STUFF_RUN));

  // R8
  end_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop || rx_err) |-> (st == S_HUNT) && !rx_active);

  // R9
  valid_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);
endmodule

// File: tb/usb_nrzi_rx_bench.sv
module usb_nrzi_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00, SE1 = 2'b11;
  localparam int EV_EOP = 256, EV_ERR = 512;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [1:0] line_st = J;
  logic [7:0] rx_data;
  logic rx_valid, rx_eop, rx_err, rx_active;

  int checks = 0, failures = 0;
  bit finished = 0;
  int    exp_q[$];
  string req_q[$];
  logic [7:0] pkt[0:7];
  logic [1:0] level;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_nrzi_rx u_usb_nrzi_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_st(line_st),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .rx_err(rx_err), .rx_active(rx_active));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int ev, input string req);
    exp_q.push_back(ev);
    req_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && (rx_valid || rx_eop || rx_err)) begin
      int got;
      got = rx_err ? EV_ERR : rx_eop ? EV_EOP : int'(rx_data);
      if (exp_q.size() == 0) check("unexpected_output", got, -1);
      else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, got, e);
      end
    end
  end

  task automatic drive(input logic [1:0] ls);
    @(negedge clk);
    line_st = ls;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en  = 1'b0;
    line_st = ~ls;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(J);
  endtask

  task automatic sync_pat();
    drive(K); drive(J); drive(K); drive(J);
    drive(K); drive(J); drive(K); drive(K);
    level = K;
  endtask

  task automatic send_bytes(input int n, input bit stuff_on);
    int ones;
    ones = 1;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (pkt[i][b]) ones++;
        else begin
          level = (level == J) ? K : J;
          ones = 0;
        end
        drive(level);
        if (stuff_on && ones == 6) begin
          level = (level == J) ? K : J;
          drive(level);
          ones = 0;
        end
      end
    end
  endtask

  task automatic good_packet(input int n, input string req);
    for (int i = 0; i < n; i++) expect_ev(int'(pkt[i]), req);
    expect_ev(EV_EOP, "R6");
    idle(3);
    sync_pat();
    send_bytes(n, 1'b1);
    drive(SE0); drive(SE0); drive(J);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1_valid", rx_valid, 0);
    check("R1_eop", rx_eop, 0);
    check("R1_err", rx_err, 0);
    check("R1_active", rx_active, 0);
    check("R1_data", rx_data, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1_idle_active", rx_active, 0);

    pkt[0] = 8'hA5; pkt[1] = 8'h00; pkt[2] = 8'h81;
    good_packet(3, "R3");

    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
    good_packet(3, "R4");

    pkt[0] = 8'h3F; pkt[1] = 8'hFC; pkt[2] = 8'h01;
    good_packet(3, "R4");

    // R5: seven ones without a stuffed zero
    expect_ev(EV_ERR, "R5");
    idle(3); sync_pat();
    pkt[0] = 8'hFF;
    send_bytes(1, 1'b0);
    drive(SE0); drive(SE0); drive(J);
    idle(2);

    // R8: recovery after error
    pkt[0] = 8'h5A;
    good_packet(1, "R8");

    // R7: SE0 mid-byte
    expect_ev(EV_ERR, "R7");
    idle(3); sync_pat();
    drive(J); drive(J); drive(K);
    drive(SE0); drive(SE0); drive(J);
    idle(2);

    // R7: SE1 inside packet
    expect_ev(EV_ERR, "R7");
    idle(3); sync_pat();
    drive(SE1);
    idle(2);

    // R7: broken end sequence
    pkt[0] = 8'h55;
    expect_ev(8'h55, "R3");
    expect_ev(EV_ERR, "R7");
    idle(3); sync_pat();
    send_bytes(1, 1'b1);
    drive(SE0); drive(K);
    idle(2);

    // R2: bad SYNC produces nothing, then a good packet
    idle(2);
    drive(K); drive(J); drive(K); drive(J);
    drive(K); drive(J); drive(K); drive(J);
    check("R2_badsync_active", rx_active, 0);
    drive(K); drive(K);
    check("R2_no_start_KK", rx_active, 0);
    pkt[0] = 8'h3C;
    good_packet(1, "R2");

    // R9: empty packet and active window
    expect_ev(EV_EOP, "R6");
    idle(3); sync_pat();
    check("R9_active_after_sync", rx_active, 1);
    drive(SE0);
    check("R9_active_in_eop", rx_active, 1);
    drive(SE0); drive(J);
    check("R9_inactive_after_eop", rx_active, 0);
    idle(4);

    check("R8_queue_drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule